// File: doc/BRIEF.md
# Configurable Macrocell Storage Element

This block is the storage element of one programmable-logic macrocell. A configuration field selects one of four behaviours: a combinational pass-through of the data sum, a D flip-flop, a T flip-flop, or a level-sensitive latch. The clock comes from one of four global clocks or from a product-term clock. The active edge, or the active level, is set by a polarity input that the whole logic block shares. Separate set and clear product terms force the element asynchronously. Each of these terms has its own polarity bit, so it can act on its true value or on its inverted value.

All inputs are sampled on a fast system clock. The selected clock is first corrected for polarity. It is then compared against its sample from the previous cycle, and a 0-to-1 change counts as the active edge. The stored value is held in a two-state machine, ST_ZERO and ST_ONE, with these transitions:

- **capture**: a D-mode edge loads the data sum.
- **toggle**: a T-mode edge with data 1 flips the state.
- **follow**: an open latch copies the data sum.
- **force-set**: an active set term drives the state to ST_ONE.
- **force-clear**: an active clear term drives the state to ST_ZERO.

Both forcing transitions take effect only outside combinational mode.

Top module: `mc_store_cell`

## Requirements
- R1: With cfg_mode = 2'b00 (combinational), q equals d_sum in the same cycle. Clocks, set and clear have no effect on q, and the stored state is left unchanged.
- R2: With cfg_mode = 2'b01 (D flip-flop), an active edge loads d_sum. The new value appears on q right after the system-clock edge that samples the active clock at 1. Between edges, q holds.
- R3: With cfg_mode = 2'b10 (T flip-flop), an active edge inverts q when d_sum is 1 and leaves q unchanged when d_sum is 0.
- R4: With cfg_mode = 2'b11 (latch), q follows d_sum combinationally while the selected clock is at its active level. When the clock leaves that level, q keeps the value it had in the last cycle of the open phase.
- R5: cfg_clk_sel values 0 to 3 pick gclk[0] to gclk[3], and value 4 picks pt_clk. Values 5 to 7 select no clock: no edge ever occurs and the latch stays closed, whatever the polarity.
- R6: With blk_clk_inv = 0, the rising edge and the high level are active. With blk_clk_inv = 1, the falling edge and the low level are active.
- R7: The set term is active when set_term XOR set_inv is 1. Outside combinational mode, an active set term with an inactive clear term drives q to 1 in the same cycle and stores 1.
- R8: The clear term is active when clr_term XOR clr_inv is 1. Outside combinational mode, an active clear term drives q to 0 in the same cycle and stores 0. The clear term wins over an active set term.
- R9: A clock edge that falls in a cycle with an active set or clear term is lost. After the term is released, q keeps the forced value until the next active edge.
- R10: While rst_n is 0, the state is ST_ZERO and the previous clock sample counts as 1. A clock that is already at its active level when reset is released therefore does not produce an edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | Fast system clock that samples every other input |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Storage behaviour: 00 comb, 01 D, 10 T, 11 latch |
| cfg_clk_sel | input | SEL_W (3) | Clock source: 0..3 global, 4 product-term, others none |
| blk_clk_inv | input | 1 | Block-level clock polarity: 1 selects the falling edge and the low level |
| gclk | input | N_GCLK (4) | Global clocks |
| pt_clk | input | 1 | Product-term clock |
| d_sum | input | 1 | Data sum feeding the element |
| set_term | input | 1 | Set product term |
| set_inv | input | 1 | Set term polarity: 1 makes it active when low |
| clr_term | input | 1 | Clear product term |
| clr_inv | input | 1 | Clear term polarity: 1 makes it active when low |
| q | output | 1 | Macrocell value |

## Verification
Two events can land in the same system cycle: an active clock edge and an asserted set or clear term. Set and clear can also be asserted together. Directed sequences place an edge with d_sum = 1 under an active clear term, and raise both terms together. The expected result is that q reads 0 in that cycle, and that q stays 0 after the release until a later edge (R8, R9). Random stimulus then mixes clock toggles with sparse forcing pulses and periodic configuration changes. A bench model compares q on every cycle, and checker properties judge edge capture and toggle only in cycles free of forcing.

// File: rtl/mc_cell_pkg.sv
package mc_cell_pkg;

    typedef enum logic [1:0] {
        MODE_COMB  = 2'b00,
        MODE_DFF   = 2'b01,
        MODE_TFF   = 2'b10,
        MODE_LATCH = 2'b11
    } store_mode_e;

    typedef enum logic {
        ST_ZERO = 1'b0,
        ST_ONE  = 1'b1
    } store_st_e;

endpackage

// File: rtl/mc_clk_front.sv
module mc_clk_front #(
    parameter int N_GCLK = 4,
    parameter int SEL_W  = 3
) (
    input  logic              clk_sys,
    input  logic              rst_n,
    input  logic [N_GCLK-1:0] gclk,
    input  logic              pt_clk,
    input  logic [SEL_W-1:0]  sel,
    input  logic              inv,
    output logic              lvl_act,
    output logic              edge_act
);
    logic raw_clk;
    logic sel_valid;
    logic prev_q;

    // Source mux: global clocks first, then the product-term clock.
    always_comb begin
        raw_clk   = 1'b0;
        sel_valid = 1'b0;
        for (int i = 0; i < N_GCLK; i++) begin
            if (sel == SEL_W'(i)) begin
                raw_clk   = gclk[i];
                sel_valid = 1'b1;
            end
        end
        if (sel == SEL_W'(N_GCLK)) begin
            raw_clk   = pt_clk;
            sel_valid = 1'b1;
        end
    end

    assign lvl_act = sel_valid & (raw_clk ^ inv);

    // The previous sample resets high, so a clock already high at release is not an edge.
    always_ff @(posedge clk_sys or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= lvl_act;
    end

    assign edge_act = lvl_act & ~prev_q;
endmodule

// File: rtl/mc_async_ctl.sv
module mc_async_ctl (
    input  logic set_term,
    input  logic set_inv,
    input  logic clr_term,
    input  logic clr_inv,
    output logic force_set,
    output logic force_clr
);
    logic set_act;
    logic clr_act;

    assign set_act   = set_term ^ set_inv;
    assign clr_act   = clr_term ^ clr_inv;
    assign force_clr = clr_act;
    assign force_set = set_act & ~clr_act;
endmodule

// File: rtl/mc_store_core.sv
module mc_store_core
    import mc_cell_pkg::*;
(
    input  logic        clk_sys,
    input  logic        rst_n,
    input  store_mode_e mode,
    input  logic        d_in,
    input  logic        lvl_act,
    input  logic        edge_act,
    input  logic        force_set,
    input  logic        force_clr,
    output logic        q
);
    store_st_e st_q;
    store_st_e st_nxt;

    // State register
    always_ff @(posedge clk_sys or negedge rst_n) begin
        if (!rst_n) st_q <= ST_ZERO;
        else        st_q <= st_nxt;
    end

    // Transitions: capture, toggle, follow, force-set, force-clear
    always_comb begin
        st_nxt = st_q;
        unique case (mode)
            MODE_COMB:  st_nxt = st_q;
            MODE_DFF:   if (edge_act) st_nxt = d_in ? ST_ONE : ST_ZERO;
            MODE_TFF:   if (edge_act && d_in) st_nxt = (st_q == ST_ONE) ? ST_ZERO : ST_ONE;
            MODE_LATCH: if (lvl_act) st_nxt = d_in ? ST_ONE : ST_ZERO;
        endcase
        if (mode != MODE_COMB) begin
            if (force_clr)      st_nxt = ST_ZERO;
            else if (force_set) st_nxt = ST_ONE;
        end
    end

    // Output process
    always_comb begin
        q = (st_q == ST_ONE);
        unique case (mode)
            MODE_COMB: q = d_in;
            MODE_DFF, MODE_TFF: begin
                if (force_clr)      q = 1'b0;
                else if (force_set) q = 1'b1;
            end
            MODE_LATCH: begin
                if (force_clr)      q = 1'b0;
                else if (force_set) q = 1'b1;
                else if (lvl_act)   q = d_in;
            end
        endcase
    end
endmodule

// File: rtl/mc_store_cell.sv
module mc_store_cell
    import mc_cell_pkg::*;
#(
    parameter int N_GCLK = 4,
    parameter int SEL_W  = $clog2(N_GCLK + 1)
) (
    input  logic              clk_sys,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic [SEL_W-1:0]  cfg_clk_sel,
    input  logic              blk_clk_inv,
    input  logic [N_GCLK-1:0] gclk,
    input  logic              pt_clk,
    input  logic              d_sum,
    input  logic              set_term,
    input  logic              set_inv,
    input  logic              clr_term,
    input  logic              clr_inv,
    output logic              q
);
    logic lvl_act;
    logic edge_act;
    logic force_set;
    logic force_clr;

    mc_clk_front #(.N_GCLK(N_GCLK), .SEL_W(SEL_W)) u_clk (
        .clk_sys (clk_sys),
        .rst_n   (rst_n),
        .gclk    (gclk),
        .pt_clk  (pt_clk),
        .sel     (cfg_clk_sel),
        .inv     (blk_clk_inv),
        .lvl_act (lvl_act),
        .edge_act(edge_act)
    );

    mc_async_ctl u_async (
        .set_term (set_term),
        .set_inv  (set_inv),
        .clr_term (clr_term),
        .clr_inv  (clr_inv),
        .force_set(force_set),
        .force_clr(force_clr)
    );

    mc_store_core u_core (
        .clk_sys  (clk_sys),
        .rst_n    (rst_n),
        .mode     (store_mode_e'(cfg_mode)),
        .d_in     (d_sum),
        .lvl_act  (lvl_act),
        .edge_act (edge_act),
        .force_set(force_set),
        .force_clr(force_clr),
        .q        (q)
    );
endmodule

// File: rtl/mc_store_cell_chk.sv
module mc_store_cell_chk #(
    parameter int N_GCLK = 4,
    parameter int SEL_W  = 3
) (
    input logic              clk_sys,
    input logic              rst_n,
    input logic [1:0]        cfg_mode,
    input logic [SEL_W-1:0]  cfg_clk_sel,
    input logic              blk_clk_inv,
    input logic [N_GCLK-1:0] gclk,
    input logic              pt_clk,
    input logic              d_sum,
    input logic              set_term,
    input logic              set_inv,
    input logic              clr_term,
    input logic              clr_inv,
    input logic              q
);
    logic c_lvl;
    logic c_set;
    logic c_clr;
    logic up_q;

    always_comb begin
        c_lvl = 1'b0;
        if (int'(cfg_clk_sel) < N_GCLK)       c_lvl = gclk[cfg_clk_sel] ^ blk_clk_inv;
        else if (int'(cfg_clk_sel) == N_GCLK) c_lvl = pt_clk ^ blk_clk_inv;
    end
    assign c_set = set_term ^ set_inv;
    assign c_clr = clr_term ^ clr_inv;

    always_ff @(posedge clk_sys or negedge rst_n) begin
        if (!rst_n) up_q <= 1'b0;
        else        up_q <= 1'b1;
    end

    // R1
    comb_pass_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (cfg_mode == 2'b00) |-> (q == d_sum));

    // R8
    clear_wins_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (cfg_mode != 2'b00 && c_clr) |-> !q);

    // R7
    set_forces_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (cfg_mode != 2'b00 && !c_clr && c_set) |-> q);

    // R2
    dff_capture_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (up_q && cfg_mode == 2'b01 && !c_clr && !c_set && c_lvl && !$past(c_lvl))
        |=> (cfg_mode != 2'b01 || c_clr || c_set || q == $past(d_sum)));

    // R3
    tff_toggle_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (up_q && cfg_mode == 2'b10 && !c_clr && !c_set && d_sum && c_lvl && !$past(c_lvl))
        |=> (cfg_mode != 2'b10 || c_clr || c_set || q != $past(q)));

    // R2
    dff_hold_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (up_q && cfg_mode == 2'b01 && !c_clr && !c_set && !(c_lvl && !$past(c_lvl)))
        |=> (cfg_mode != 2'b01 || c_clr || c_set || $stable(q)));
endmodule

bind mc_store_cell mc_store_cell_chk #(.N_GCLK(N_GCLK), .SEL_W(SEL_W)) u_chk (
    .clk_sys    (clk_sys),
    .rst_n      (rst_n),
    .cfg_mode   (cfg_mode),
    .cfg_clk_sel(cfg_clk_sel),
    .blk_clk_inv(blk_clk_inv),
    .gclk       (gclk),
    .pt_clk     (pt_clk),
    .d_sum      (d_sum),
    .set_term   (set_term),
    .set_inv    (set_inv),
    .clr_term   (clr_term),
    .clr_inv    (clr_inv),
    .q          (q)
);

// File: tb/test_mc_store_cell.sv
`timescale 1ns/1ps
module test_mc_store_cell;
    logic       clk_sys = 1'b0;
    logic       rst_n   = 1'b0;
    logic [1:0] cfg_mode = 2'b01;
    logic [2:0] cfg_clk_sel = 3'd0;
    logic       blk_clk_inv = 1'b0;
    logic [3:0] gclk = 4'h0;
    logic       pt_clk = 1'b0;
    logic       d_sum = 1'b0;
    logic       set_term = 1'b0, set_inv = 1'b0, clr_term = 1'b0, clr_inv = 1'b0;
    logic       q;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  ref_st = 1'b0;
    bit  ref_prev = 1'b1;
    bit  done = 1'b0;

    always #2.5 clk_sys = ~clk_sys;

    mc_store_cell i_mc_store_cell (
        .clk_sys(clk_sys), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_clk_sel(cfg_clk_sel),
        .blk_clk_inv(blk_clk_inv), .gclk(gclk), .pt_clk(pt_clk), .d_sum(d_sum),
        .set_term(set_term), .set_inv(set_inv), .clr_term(clr_term), .clr_inv(clr_inv), .q(q)
    );

    // R5, R6: source choice and polarity
    function automatic bit f_lvl();
        if (cfg_clk_sel < 3'd4)  return gclk[cfg_clk_sel[1:0]] ^ blk_clk_inv;
        if (cfg_clk_sel == 3'd4) return pt_clk ^ blk_clk_inv;
        return 1'b0;
    endfunction

    function automatic bit f_set(); return set_term ^ set_inv; endfunction
    function automatic bit f_clr(); return clr_term ^ clr_inv; endfunction

    function automatic bit f_exp_q();
        if (cfg_mode == 2'b00) return d_sum;
        if (f_clr())           return 1'b0;
        if (f_set())           return 1'b1;
        if (cfg_mode == 2'b11 && f_lvl()) return d_sum;
        return ref_st;
    endfunction

    function automatic string f_tag();
        if (cfg_mode == 2'b00) return "R1";
        if (f_clr())           return "R8";
        if (f_set())           return "R7";
        if (cfg_mode == 2'b01) return "R2";
        if (cfg_mode == 2'b10) return "R3";
        return "R4";
    endfunction

    task automatic compare(input bit got, input bit exp, input string tag);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: q=%0b expected %0b", tag, $time, got, exp);
        end
    endtask

    // One cycle: check q on current inputs, then advance the model at the edge.
    task automatic tick(input string tag);
        bit lvl, edg;
        #1;
        compare(q, f_exp_q(), (tag == "") ? f_tag() : tag);
        @(posedge clk_sys);
        lvl = f_lvl();
        edg = lvl && !ref_prev;
        if (cfg_mode != 2'b00) begin
            case (cfg_mode)
                2'b01: if (edg) ref_st = d_sum;
                2'b10: if (edg && d_sum) ref_st = ~ref_st;
                2'b11: if (lvl) ref_st = d_sum;
                default: ;
            endcase
            if (f_clr())      ref_st = 1'b0;
            else if (f_set()) ref_st = 1'b1;
        end
        ref_prev = lvl;
        @(negedge clk_sys);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R10: reset state with the selected clock held high
        cfg_mode = 2'b01; cfg_clk_sel = 3'd0; gclk = 4'h1; d_sum = 1'b1;
        repeat (3) @(negedge clk_sys);
        #1 compare(q, 1'b0, "R10");
        rst_n = 1'b1;
        tick("R10");
        tick("R10");            // clock high at release gives no edge: q stays 0
        gclk = 4'h0; tick("R2");
        gclk = 4'h1; tick("R2"); // edge sampled here
        #1 compare(q, 1'b1, "R2");
        d_sum = 1'b0; tick("R2"); // no new edge: hold
        #1 compare(q, 1'b1, "R2");

        // R6: falling edge on gclk[1]
        cfg_clk_sel = 3'd1; blk_clk_inv = 1'b1; gclk = 4'h2; tick("R6");
        gclk = 4'h0; tick("R6");
        #1 compare(q, 1'b0, "R6");

        // R3: toggle on product-term clock (R5 select 4)
        cfg_mode = 2'b10; cfg_clk_sel = 3'd4; blk_clk_inv = 1'b0; d_sum = 1'b1;
        pt_clk = 1'b0; tick("R5");
        pt_clk = 1'b1; tick("R3");
        #1 compare(q, 1'b1, "R3");
        pt_clk = 1'b0; d_sum = 1'b0; tick("R3");
        pt_clk = 1'b1; tick("R3");
        #1 compare(q, 1'b1, "R3");

        // R5: unused select, latch never opens even with inverted polarity
        cfg_mode = 2'b11; cfg_clk_sel = 3'd6; blk_clk_inv = 1'b1;
        for (int i = 0; i < 8; i++) begin
            d_sum = i[0]; gclk = 4'(i); pt_clk = i[1]; tick("R5");
        end
        #1 compare(q, 1'b1, "R5");

        // R4: latch transparent on low level of gclk[2]
        cfg_clk_sel = 3'd2; gclk = 4'h0; d_sum = 1'b0; tick("R4");
        #1 compare(q, 1'b0, "R4");
        d_sum = 1'b1; #1 compare(q, 1'b1, "R4");
        tick("R4");
        gclk = 4'h4; d_sum = 1'b0; tick("R4");
        #1 compare(q, 1'b1, "R4");

        // R8/R9: edge under active clear is lost; set+clear gives 0
        cfg_mode = 2'b01; cfg_clk_sel = 3'd3; blk_clk_inv = 1'b0; gclk = 4'h0; d_sum = 1'b1;
        set_term = 1'b1; tick("R7");
        #1 compare(q, 1'b1, "R7");
        clr_inv = 1'b1; clr_term = 1'b0; gclk = 4'h8; tick("R8");
        clr_term = 1'b1; set_term = 1'b0; tick("R9");
        #1 compare(q, 1'b0, "R9");
        set_inv = 1'b1; set_term = 1'b0; clr_term = 1'b0; tick("R8");
        #1 compare(q, 1'b0, "R8");
        set_inv = 1'b0; clr_term = 1'b1; tick("R9");
        #1 compare(q, 1'b0, "R9");

        // R1: combinational mode ignores forcing terms
        cfg_mode = 2'b00; set_term = 1'b1;
        for (int i = 0; i < 4; i++) begin
            d_sum = i[0]; clr_term = i[1]; tick("R1");
        end

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            if (n % 40 == 0) begin
                cfg_mode    = 2'($urandom);
                cfg_clk_sel = 3'($urandom);
                blk_clk_inv = 1'($urandom);
                set_inv     = 1'($urandom);
                clr_inv     = 1'($urandom);
            end
            gclk     = 4'($urandom);
            pt_clk   = 1'($urandom);
            d_sum    = 1'($urandom);
            set_term = set_inv ^ (($urandom % 8) == 0);
            clr_term = clr_inv ^ (($urandom % 12) == 0);
            tick("");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule